// File: doc/BRIEF.md
# Secure Seconds Counter with Alarm

This block keeps time for a security monitor. It runs on a 32.768 kHz low-power clock and holds a 47-bit count. The upper 32 bits are whole seconds and the lower 15 bits are a sub-second fraction, so the fraction wraps once per second. A seconds comparator raises a sticky alarm flag. An interrupt output reports that flag when its enable is set.

Software reaches the counter through a register port: a write strobe with a word address and data, plus a separate read address that returns data combinationally. Counting is gated by several conditions: the enable, an overflow flag, a non-valid flag, a failure-state input, and whether the seconds word has been loaded since power-on. Two lock inputs, a soft one and a hard one, prevent a stopped counter from being set or started. Reset models loss of battery power. It leaves the unit non-valid, with the counter stopped and the alarm set to its "none" value.

Top module: `secure_rtc_core`

## Requirements
- R1: After reset, seconds, fraction, enable and all status flags other than non-valid read zero. Non-valid (status bit 1) reads one, alarm seconds reads all ones, alarm interrupt enable reads zero and the interrupt output is low.
- R2: While running, the fraction rises by one on each clock. When the fraction is all ones, the next clock clears it and adds one to seconds.
- R3: The alarm flag (status bit 4) is set on the clock where seconds steps to a value equal to alarm seconds. It is set once per match and stays set until cleared. The interrupt output is high exactly while this flag and the alarm interrupt enable (interrupt-enable register bit 4) are both set.
- R4: The counter holds its value whenever any of the following is true: the enable (control bit 3) is clear, the overflow flag is set, the non-valid flag is set, or the failure input is high.
- R5: When the full 47-bit count is all ones and the counter is running, the next clock sets the overflow flag (status bit 2). The count then stays at all ones instead of wrapping.
- R6: While the enable is clear and either lock input is high, writes to seconds, fraction and control are ignored. While the enable is set, the locks do not block time writes. The lock inputs read back on control bits 17 (soft) and 18 (hard).
- R7: An alarm seconds value of all ones never sets the alarm flag, even when seconds steps to all ones.
- R8: Writing a one to status bit 4, 2 or 1 clears that flag. Writing a zero leaves it unchanged. When a clear and a new set of the same flag fall on one clock, the set wins.
- R9: The alarm fraction word (address 3) always reads zero and ignores writes. Status bit 0 reflects the failure input.
- R10: After reset the counter does not advance until an accepted write to the seconds word (address 0), even with the enable set and non-valid cleared.

Register word addresses: 0 seconds, 1 fraction, 2 alarm seconds, 3 alarm fraction, 4 control, 5 status, 6 interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz counting clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| fail_i | input | 1 | Unit is in the failure state |
| lock_soft_i | input | 1 | Soft lock on setting the time |
| lock_hard_i | input | 1 | Hard lock on setting the time |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write word address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read word address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| alarm_irq_o | output | 1 | Alarm interrupt |

## Verification
Every register write takes effect on the clock edge that samples the strobe. Counting begins on the edge after that. The fraction therefore reaches a value k steps ahead k edges after the enabling write, and a seconds step, alarm set or overflow lands on the edge where the count crosses its boundary. Read data and the interrupt are combinational from the registers. The bench drives on falling edges and checks one nanosecond after a falling edge. It counts the exact number of falling edges from a write's return to the edge that should change the result. It checks the cycle before that edge as well as the cycle after, so a result that arrives one edge early or late is caught.

// File: rtl/secure_rtc_core.sv
module secure_rtc_core #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fail_i,
  input  logic              lock_soft_i,
  input  logic              lock_hard_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              alarm_irq_o
);
  localparam logic [ADDR_W-1:0] A_SEC = 0, A_FRAC = 1, A_ASEC = 2, A_AFRAC = 3,
                                A_CTRL = 4, A_STAT = 5, A_IE = 6;
  localparam int B_EN = 3, B_SOFT = 17, B_HARD = 18;
  localparam int B_AF = 4, B_OVF = 2, B_NV = 1, B_FAIL = 0;

  logic [SEC_W-1:0]  sec_q, alarm_q;
  logic [FRAC_W-1:0] frac_q;
  logic en_q, nv_q, ovf_q, af_q, ie_q, armed_q;

  wire wr_sec  = wr_en_i && (wr_addr_i == A_SEC);
  wire wr_frac = wr_en_i && (wr_addr_i == A_FRAC);
  wire wr_asec = wr_en_i && (wr_addr_i == A_ASEC);
  wire wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
  wire wr_stat = wr_en_i && (wr_addr_i == A_STAT);
  wire wr_ie   = wr_en_i && (wr_addr_i == A_IE);

  wire locked   = !en_q && (lock_soft_i || lock_hard_i);
  wire run      = en_q && armed_q && !ovf_q && !nv_q && !fail_i;
  wire frac_top = &frac_q;
  wire at_top   = frac_top && (&sec_q);
  wire tick     = run && frac_top && !at_top;
  wire [SEC_W-1:0] sec_inc = sec_q + 1'b1;
  wire hit      = tick && (sec_inc == alarm_q) && !(&alarm_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q   <= '0;
      frac_q  <= '0;
      alarm_q <= '1;
      en_q    <= 1'b0;
      nv_q    <= 1'b1;
      ovf_q   <= 1'b0;
      af_q    <= 1'b0;
      ie_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wr_stat) begin
        if (wr_data_i[B_AF])  af_q  <= 1'b0;
        if (wr_data_i[B_OVF]) ovf_q <= 1'b0;
        if (wr_data_i[B_NV])  nv_q  <= 1'b0;
      end
      if (run) begin
        if (at_top) ovf_q <= 1'b1;
        else if (frac_top) begin
          frac_q <= '0;
          sec_q  <= sec_inc;
        end else frac_q <= frac_q + 1'b1;
      end
      if (hit) af_q <= 1'b1;
      if (wr_frac && !locked) frac_q <= wr_data_i[FRAC_W-1:0];
      if (wr_sec && !locked) begin
        sec_q   <= wr_data_i[SEC_W-1:0];
        armed_q <= 1'b1;
      end
      if (wr_ctrl && !locked) en_q <= wr_data_i[B_EN];
      if (wr_asec) alarm_q <= wr_data_i[SEC_W-1:0];
      if (wr_ie)   ie_q    <= wr_data_i[B_AF];
    end
  end

  assign alarm_irq_o = af_q && ie_q;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_SEC:   rd_data_o[SEC_W-1:0]  = sec_q;
      A_FRAC:  rd_data_o[FRAC_W-1:0] = frac_q;
      A_ASEC:  rd_data_o[SEC_W-1:0]  = alarm_q;
      A_AFRAC: rd_data_o = '0;
      A_CTRL: begin
        rd_data_o[B_EN]   = en_q;
        rd_data_o[B_SOFT] = lock_soft_i;
        rd_data_o[B_HARD] = lock_hard_i;
      end
      A_STAT: begin
        rd_data_o[B_AF]   = af_q;
        rd_data_o[B_OVF]  = ovf_q;
        rd_data_o[B_NV]   = nv_q;
        rd_data_o[B_FAIL] = fail_i;
      end
      A_IE:    rd_data_o[B_AF] = ie_q;
      default: rd_data_o = '0;
    endcase
  end

  p_hold_when_stopped_r4: assert property (@(posedge clk) disable iff (rst)
    (!(en_q && armed_q) || ovf_q || nv_q || fail_i) && !wr_sec && !wr_frac
    |=> $stable(sec_q) && $stable(frac_q));

  p_overflow_saturates_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> (&sec_q) && (&frac_q));

  p_alarm_on_match_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(af_q) |-> (sec_q == $past(alarm_q)) || $past(wr_sec));

  p_no_alarm_value_r7: assert property (@(posedge clk) disable iff (rst)
    (&alarm_q) && !af_q |=> !af_q);

  p_locked_sec_write_r6: assert property (@(posedge clk) disable iff (rst)
    locked && wr_sec |=> $stable(sec_q));

  p_nv_clear_r8: assert property (@(posedge clk) disable iff (rst)
    wr_stat && wr_data_i[B_NV] |=> !nv_q);
endmodule

// File: tb/secure_rtc_core_tb.sv
module secure_rtc_core_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic fail_i = 1'b0, lock_soft_i = 1'b0, lock_hard_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic alarm_irq_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  secure_rtc_core u_dut (
    .clk(clk), .rst(rst), .fail_i(fail_i), .lock_soft_i(lock_soft_i),
    .lock_hard_i(lock_hard_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .alarm_irq_o(alarm_irq_o));

  task automatic chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    rd_addr_i = a;
    #1;
    n_chk++;
    if (rd_data_o !== exp) begin
      n_fail++;
      $display("FAIL %s addr %0d: actual %h expected %h", tag, a, rd_data_o, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    #1;
    n_chk++;
    if (alarm_irq_o !== exp) begin
      n_fail++;
      $display("FAIL %s irq: actual %b expected %b", tag, alarm_irq_o, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    fail_i = 1'b0; lock_soft_i = 1'b0; lock_hard_i = 1'b0;
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk(0, 32'h0, "R1 seconds");
    chk(1, 32'h0, "R1 fraction");
    chk(2, 32'hFFFF_FFFF, "R1 alarm");
    chk(4, 32'h0, "R1 control");
    chk(5, 32'h2, "R1 status");
    chk(6, 32'h0, "R1 irq enable");
    chk_irq(1'b0, "R1");
  endtask

  task automatic t_count();
    do_reset();
    wr(5, 32'h2);
    chk(5, 32'h0, "R8 nv cleared");
    wr(4, 32'h8);
    wait_n(5);
    chk(1, 32'h0, "R10 no count before seconds write");
    wr(1, 32'h7FFD);
    wr(0, 32'd10);
    wait_n(4);
    chk(0, 32'd11, "R2 seconds step");
    chk(1, 32'd1, "R2 fraction after wrap");
    fail_i = 1'b1;
    wait_n(5);
    chk(1, 32'd1, "R4 held by failure");
    chk(5, 32'h1, "R9 failure readback");
    fail_i = 1'b0;
    wait_n(2);
    chk(1, 32'd3, "R2 resumes");
    wr(4, 32'h0);
    wait_n(4);
    chk(1, 32'd4, "R4 held by enable clear");
  endtask

  task automatic t_overflow();
    do_reset();
    wr(5, 32'h2);
    wr(1, 32'h7FFE);
    wr(0, 32'hFFFF_FFFE);
    wr(4, 32'h8);
    wait_n(2);
    chk(0, 32'hFFFF_FFFF, "R7 seconds reached all ones");
    chk(5, 32'h0, "R7 no alarm flag");
    wr(1, 32'h7FFE);
    wait_n(1);
    chk(5, 32'h0, "R5 no overflow yet");
    wait_n(1);
    chk(5, 32'h4, "R5 overflow flag");
    wait_n(5);
    chk(0, 32'hFFFF_FFFF, "R5 seconds held");
    chk(1, 32'h7FFF, "R5 fraction held");
  endtask

  task automatic t_alarm();
    do_reset();
    wr(5, 32'h2);
    wr(2, 32'd5);
    wr(3, 32'h123);
    chk(3, 32'h0, "R9 alarm fraction reads zero");
    wr(1, 32'h7FFE);
    wr(0, 32'd4);
    wr(4, 32'h8);
    wait_n(1);
    chk(5, 32'h0, "R3 flag not early");
    wait_n(1);
    chk(5, 32'h10, "R3 flag set on match");
    chk(0, 32'd5, "R3 seconds at match");
    chk_irq(1'b0, "R3 masked");
    wr(6, 32'h10);
    chk_irq(1'b1, "R3 enabled");
    wr(5, 32'h10);
    chk(5, 32'h0, "R8 alarm flag cleared");
    chk_irq(1'b0, "R8 irq drops");
    wait_n(10);
    chk(5, 32'h0, "R3 fires once");
  endtask

  task automatic t_lock();
    do_reset();
    wr(5, 32'h2);
    lock_soft_i = 1'b1;
    wr(0, 32'd77);
    chk(0, 32'h0, "R6 soft lock blocks seconds");
    wr(4, 32'h8);
    chk(4, 32'h0002_0000, "R6 soft lock blocks enable");
    lock_soft_i = 1'b0; lock_hard_i = 1'b1;
    wr(1, 32'h55);
    chk(1, 32'h0, "R6 hard lock blocks fraction");
    chk(4, 32'h0004_0000, "R6 hard lock readback");
    lock_hard_i = 1'b0;
    wr(4, 32'h8);
    lock_hard_i = 1'b1;
    wr(0, 32'd77);
    chk(0, 32'd77, "R6 enabled counter accepts seconds");
  endtask

  initial begin
    wait_n(150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_count();
    t_overflow();
    t_alarm();
    t_lock();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule